// File: doc/BRIEF.md
# Narrow-to-wide memory reshaper

The block offers a deep memory of narrow words with one write port and one read port. Behind that interface it stores the data in a shallower memory whose rows are several narrow words wide. Each row holds `WAYS` narrow words, called lanes. The low bits of a user address pick the lane, and the remaining bits pick the row.

A write updates only its own lane. The write path moves the narrow data into the lane's bit position and raises that lane's write-enable bit in a per-lane mask. The other lanes of the row keep their contents, so no read-modify-write cycle is needed. A read fetches the whole row into a register and records the lane index in the same cycle. One cycle later the recorded index selects the narrow word out of that registered row.

Both ports are plain enable-qualified requests with no back-pressure. Every request with its enable high is accepted on that clock edge. Read data arrives exactly one read-clock cycle later, together with a one-cycle valid flag, and the consumer cannot stall it. The two port clocks are separate pins. The block does nothing to cross data between two unrelated clocks.

Top module: `nw_reshape_mem`

## Requirements
- R1: User address bits `[WAY_BITS-1:0]` (two bits by default) select the lane, and the upper bits select the wide row. Every one of the `ROWS*WAYS` narrow addresses stores an independent word.
- R2: A write with `wr_en` high changes exactly one lane of one row, the addressed one. Exactly one bit of the internal lane mask is set during such a write.
- R3: A read returns the word held in bits `[NARROW_W*lane +: NARROW_W]` of the addressed row, where lane is the address's low bits. The narrow word written last to that address is returned.
- R4: `rd_valid` is high in the read-clock cycle after a cycle with `rd_en` high, and low after a cycle with `rd_en` low. `rd_data` is updated on that same edge.
- R5: When `rd_en` is low, `rd_data` keeps its previous value, even across writes.
- R6: A write and a read issued in the same cycle to different lanes of the same row do not disturb each other. The read returns its lane's stored word, and the write lands in its own lane.
- R7: A read and a write to the same address in the same cycle return the value held before the write. A later read returns the new value.
- R8: With `wr_en` low, `wr_addr` and `wr_data` have no effect on the stored contents, and the lane mask is all zero.
- R9: While `rst_n` is low, and after its release until the first read, `rd_valid` and `rd_data` are zero.
- R10: `WAYS` must be a power of two and at least 2. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| rd_clk | input | 1 | Read port clock |
| rst_n | input | 1 | Active-low asynchronous reset of the read output registers |
| wr_en | input | 1 | Write request, accepted on the rising edge of wr_clk |
| wr_addr | input | ADDR_W (8) | Narrow write address |
| wr_data | input | NARROW_W (2) | Narrow write data |
| rd_en | input | 1 | Read request, accepted on the rising edge of rd_clk |
| rd_addr | input | ADDR_W (8) | Narrow read address |
| rd_data | output | NARROW_W (2) | Read data, one cycle after the request |
| rd_valid | output | 1 | High for one cycle when rd_data carries a new result |

## Verification
The bench goes after same-row traffic. It writes one lane while reading a sibling lane of the same row in the same cycle. A design that wrote the whole row, or used an all-ones mask, would wipe out the neighbouring words. It also reads and writes one address in the same cycle. A design that read after writing would return the new value instead of the old one, and a design that took the lane index from the live address instead of the recorded one would return the wrong lane. Idle cycles with a changing read address or a disabled write catch a result that does not hold or a write that leaks through.

// File: rtl/nw_reshape_pkg.sv
package nw_reshape_pkg;

  // True when n is a power of two and at least 2.
  function automatic bit lanes_ok(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction

  // Width of an index able to hold 0..n-1, never below 1.
  function automatic int idx_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/nw_lane_pack.sv
module nw_lane_pack #(
  parameter int NARROW_W = 2,
  parameter int WAYS     = 4,
  parameter int ROW_W    = 6,
  localparam int WAY_BITS = $clog2(WAYS),
  localparam int ADDR_W   = ROW_W + WAY_BITS,
  localparam int WIDE_W   = NARROW_W * WAYS
) (
  input  logic                wr_clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NARROW_W-1:0] wr_data,
  output logic                w_en,
  output logic [ROW_W-1:0]    w_row,
  output logic [WIDE_W-1:0]   w_data,
  output logic [WAYS-1:0]     w_mask
);

  logic [WAY_BITS-1:0] way;

  assign way   = wr_addr[WAY_BITS-1:0];
  assign w_row = wr_addr[ADDR_W-1:WAY_BITS];
  assign w_en  = wr_en;

  // One lane slot per way: data lands in its slot, all others are zero.
  for (genvar g = 0; g < WAYS; g++) begin : g_lane
    logic hit;
    assign hit = (way == WAY_BITS'(g));
    assign w_data[g*NARROW_W +: NARROW_W] = hit ? wr_data : '0;
    assign w_mask[g] = wr_en & hit;
  end

  // R2: an accepted write enables exactly one lane
  p_mask_onehot_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_en |-> ($countones(w_mask) == 1));

  // R8: an idle write port enables no lane
  p_idle_mask_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_en |-> (w_mask == '0));

  // R2: the lane whose mask bit is clear carries zero data
  p_unmasked_zero_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $onehot0(w_mask) && ((w_data & ~{NARROW_W{1'b1}}) != '0) |-> (w_mask[0] == 1'b0));

endmodule

// File: rtl/nw_wide_store.sv
module nw_wide_store #(
  parameter int NARROW_W = 2,
  parameter int WAYS     = 4,
  parameter int ROWS     = 64,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int WIDE_W  = NARROW_W * WAYS
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              w_en,
  input  logic [ROW_W-1:0]  w_row,
  input  logic [WIDE_W-1:0] w_data,
  input  logic [WAYS-1:0]   w_mask,
  input  logic              r_en,
  input  logic [ROW_W-1:0]  r_row,
  output logic [WIDE_W-1:0] r_data
);

  // Each lane is its own narrow array. The mask bit is that lane's write enable.
  for (genvar g = 0; g < WAYS; g++) begin : g_bank
    logic [NARROW_W-1:0] cells [ROWS];
    logic [NARROW_W-1:0] q;

    always_ff @(posedge wr_clk) begin
      if (w_en && w_mask[g]) begin
        cells[w_row] <= w_data[g*NARROW_W +: NARROW_W];
      end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (r_en) begin
        q <= cells[r_row];
      end
    end

    assign r_data[g*NARROW_W +: NARROW_W] = q;
  end

  // R5: the registered row only moves on a read
  p_row_hold_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !r_en |=> $stable(r_data));

endmodule

// File: rtl/nw_lane_pick.sv
module nw_lane_pick #(
  parameter int NARROW_W = 2,
  parameter int WAYS     = 4,
  localparam int WAY_BITS = $clog2(WAYS),
  localparam int WIDE_W   = NARROW_W * WAYS
) (
  input  logic                rd_clk,
  input  logic                rst_n,
  input  logic                r_en,
  input  logic [WAY_BITS-1:0] r_way,
  input  logic [WIDE_W-1:0]   row_q,
  output logic [NARROW_W-1:0] lane_q,
  output logic                valid_q
);

  logic [WAY_BITS-1:0] way_q;

  // The lane index is recorded on the same edge as the row read.
  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      way_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= r_en;
      if (r_en) begin
        way_q <= r_way;
      end
    end
  end

  always_comb begin
    lane_q = '0;
    for (int k = 0; k < WAYS; k++) begin
      if (way_q == WAY_BITS'(k)) begin
        lane_q = row_q[k*NARROW_W +: NARROW_W];
      end
    end
  end

  // R4: valid follows the request by one cycle
  p_valid_follows_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    r_en |=> valid_q);

  p_valid_clears_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !r_en |=> !valid_q);

  // R3: the recorded lane matches the address of the request
  p_way_capture_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    r_en |=> (way_q == $past(r_way)));

endmodule

// File: rtl/nw_reshape_mem.sv
module nw_reshape_mem #(
  parameter int NARROW_W = 2,
  parameter int WAYS     = 4,
  parameter int ROWS     = 64,
  localparam int WAY_BITS = $clog2(WAYS),
  localparam int ROW_W    = $clog2(ROWS),
  localparam int ADDR_W   = ROW_W + WAY_BITS,
  localparam int WIDE_W   = NARROW_W * WAYS
) (
  input  logic                wr_clk,
  input  logic                rd_clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [NARROW_W-1:0] wr_data,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [NARROW_W-1:0] rd_data,
  output logic                rd_valid
);

  // R10: lane count must be a power of two
  if (!nw_reshape_pkg::lanes_ok(WAYS)) begin : g_bad_ways
    $error("nw_reshape_mem: WAYS must be a power of two, at least 2 (R10)");
  end

  logic              w_en;
  logic [ROW_W-1:0]  w_row;
  logic [WIDE_W-1:0] w_data;
  logic [WAYS-1:0]   w_mask;
  logic [WIDE_W-1:0] row_q;

  nw_lane_pack #(
    .NARROW_W(NARROW_W),
    .WAYS    (WAYS),
    .ROW_W   (ROW_W)
  ) u_pack (
    .wr_clk (wr_clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .w_en   (w_en),
    .w_row  (w_row),
    .w_data (w_data),
    .w_mask (w_mask)
  );

  nw_wide_store #(
    .NARROW_W(NARROW_W),
    .WAYS    (WAYS),
    .ROWS    (ROWS)
  ) u_store (
    .wr_clk(wr_clk),
    .rd_clk(rd_clk),
    .rst_n (rst_n),
    .w_en  (w_en),
    .w_row (w_row),
    .w_data(w_data),
    .w_mask(w_mask),
    .r_en  (rd_en),
    .r_row (rd_addr[ADDR_W-1:WAY_BITS]),
    .r_data(row_q)
  );

  nw_lane_pick #(
    .NARROW_W(NARROW_W),
    .WAYS    (WAYS)
  ) u_pick (
    .rd_clk (rd_clk),
    .rst_n  (rst_n),
    .r_en   (rd_en),
    .r_way  (rd_addr[WAY_BITS-1:0]),
    .row_q  (row_q),
    .lane_q (rd_data),
    .valid_q(rd_valid)
  );

  // R5: output word holds between reads
  p_data_hold_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R4: a fresh result is flagged for exactly one cycle unless reads continue
  p_valid_pulse_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(rd_en));

endmodule

// File: tb/nw_reshape_mem_tb.sv
`timescale 1ns/1ps
module nw_reshape_mem_tb;
  localparam int N     = 2;
  localparam int WAYS  = 4;
  localparam int ROWS  = 64;
  localparam int AW    = 8;
  localparam int DEPTH = ROWS * WAYS;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [N-1:0]  wr_data;
  logic [N-1:0]  rd_data;
  logic          rd_valid;

  logic [N-1:0]  model [DEPTH];
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  nw_reshape_mem #(.NARROW_W(N), .WAYS(WAYS), .ROWS(ROWS)) u_dut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [N-1:0] fill_word(input int a);
    return N'((a * 7 + 1) & 3);
  endfunction

  // Address in the same row as a, lane shifted by k.
  function automatic int sibling(input int a, input int k);
    return (a & ~(WAYS - 1)) | ((a + k) & (WAYS - 1));
  endfunction

  function automatic logic [N-1:0] expect_read(input int a);
    return model[a];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at next falling edge.
  task automatic op(input bit we, input int wa, input logic [N-1:0] wd,
                    input bit re, input int ra, input string req);
    logic [N-1:0] exp_d;
    logic [N-1:0] prev;
    wr_en   = we;
    wr_addr = AW'(wa);
    wr_data = wd;
    rd_en   = re;
    rd_addr = AW'(ra);
    prev    = rd_data;
    exp_d   = expect_read(ra);
    if (we) model[wa] = wd;
    @(negedge clk);
    if (re) begin
      check(rd_valid === 1'b1, {req, " R4 valid"}, int'(rd_valid), 1);
      check(rd_data === exp_d, req, int'(rd_data), int'(exp_d));
    end else begin
      check(rd_valid === 1'b0, {req, " R4 idle"}, int'(rd_valid), 0);
      check(rd_data === prev, {req, " R5 hold"}, int'(rd_data), int'(prev));
    end
  endtask

  initial begin
    int a;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(rd_valid === 1'b0, "R9 valid in reset", int'(rd_valid), 0);
    check(rd_data === '0, "R9 data in reset", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data === '0, "R9 data after release", int'(rd_data), 0);

    for (int i = 0; i < DEPTH; i++) op(1'b1, i, fill_word(i), 1'b0, 0, "R8 fill");
    for (int i = 0; i < DEPTH; i++) op(1'b0, 0, '0, 1'b1, i, "R1 R3 readback");

    // R2: rewrite one lane, siblings must stay
    op(1'b1, 37, ~fill_word(37), 1'b0, 0, "R2 write");
    for (int k = 0; k < WAYS; k++) op(1'b0, 0, '0, 1'b1, sibling(37, k), "R2 sibling");

    // R6: same row, different lane, same cycle
    for (int k = 1; k < WAYS; k++) begin
      a = 80 + k;
      op(1'b1, 80, N'(k), 1'b1, a, "R6 read sibling");
      op(1'b0, 0, '0, 1'b1, 80, "R6 write landed");
    end

    // R7: same address collision returns old, then new
    op(1'b1, 5, ~model[5], 1'b1, 5, "R7 old value");
    op(1'b0, 0, '0, 1'b1, 5, "R7 new value");

    // R8: disabled write with live address and data
    wr_en = 1'b0;
    op(1'b0, 12, ~model[12], 1'b0, 12, "R8 idle write");
    op(1'b0, 0, '0, 1'b1, 12, "R8 unchanged");

    // R5: hold across writes and read-address changes
    op(1'b1, 200, ~model[200], 1'b0, 201, "R5 hold w");
    op(1'b0, 0, '0, 1'b0, 7, "R5 hold idle");

    for (int i = 0; i < 2000; i++) begin
      bit we, re;
      int wa, ra;
      we = ($urandom % 4) != 0;
      re = ($urandom % 4) != 0;
      wa = int'($urandom % DEPTH);
      ra = (($urandom % 3) == 0) ? sibling(wa, int'($urandom % WAYS)) : int'($urandom % DEPTH);
      op(we, wa, N'($urandom), re, ra, "R3 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", 200000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule